// File: doc/BRIEF.md
# Memory Bank Selector for a Split 64 KB Address Space

The block maps a 64 KB processor address space onto a set of memories. The space is split into a lower and an upper 32 KB half, and each half is served by one source at a time. An 8-bit control byte, loaded through a write strobe from an output port, decides which source that is. The lower half can show a boot ROM, a cartridge ROM or one of two expansion RAM banks. The upper half can show base RAM or one of two expansion RAM banks. When the cartridge owns the lower half, two separate 16 KB windows of cartridge ROM can also be laid over the upper half.

For every access the block raises at most one chip select and, for writable RAM only, the matching write enable. When no memory answers, it raises `read_empty` instead, and the data path must then return 0xFF. The cases with no answering memory are an unfitted cartridge, an unfitted expansion bank, and the blanked part of base RAM in the reduced model. Static inputs declare which banks are fitted and whether the reduced-RAM model applies. Bit 5 of the control byte drives a caps-lock indicator. The decode is combinational from the control register and the address. Only the control register holds state.

Top module: `bank_map_top`

## Requirements
- R1: After reset the control register holds 0xFF. The lower half then selects the boot ROM (chip_sel bit 0), the upper half selects base RAM (chip_sel bit 4), and caps_led_on is 0.
- R2: In the lower half (cpu_addr[15]=0) the source follows a fixed priority over active-low control bits. Bit 0 low selects the cartridge (chip_sel bit 1). Otherwise bit 1 low selects lower expansion bank A (bit 5). Otherwise bit 3 low selects lower expansion bank B (bit 6). Otherwise the boot ROM is selected (bit 0).
- R3: In the upper half, outside an active cartridge window, bit 2 low selects upper expansion bank A (chip_sel bit 7). Otherwise bit 4 low selects upper expansion bank B (bit 8). Otherwise base RAM is selected (bit 4).
- R4: When control bit 0 is low, an upper-half access with cpu_addr[14]=0 and bit 6 low selects cartridge window A (chip_sel bit 2). An access with cpu_addr[14]=1 and bit 7 low selects cartridge window B (bit 3). A window replaces any RAM choice there. With bit 0 high the windows never open.
- R5: wr_en has a bit set only when cpu_wr is 1, and only for the selected RAM target (bits 4, 5, 6, 7, 8). ROM targets (bits 0 to 3) are never write-enabled.
- R6: With reduced_ram=1, base RAM at upper-half addresses with cpu_addr[14]=0 is not selected and not written, and read_empty is 1. The top 16 KB of base RAM behaves normally.
- R7: A selection of the cartridge (cart_fitted=0) or of an expansion bank whose xram_fitted bit is 0 gives no chip select and no write enable, and read_empty is 1. The xram_fitted bits are: bit 0 lower A, bit 1 lower B, bit 2 upper A, bit 3 upper B.
- R8: caps_led_on is the inverse of control bit 5.
- R9: A byte on ctl_wr_data is loaded when ctl_wr_en is 1 at a rising clock edge and takes effect from that edge on. With ctl_wr_en at 0 the register keeps its value whatever ctl_wr_data carries.
- R10: For every access exactly one of these holds: a single chip_sel bit is set, or read_empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads 0xFF into the control register |
| ctl_wr_en | input | 1 | Load strobe for the control register |
| ctl_wr_data | input | 8 | Control byte to load |
| cpu_addr | input | 16 | Processor address |
| cpu_wr | input | 1 | Processor write cycle |
| reduced_ram | input | 1 | Static: reduced model, only the top 16 KB of base RAM exists |
| cart_fitted | input | 1 | Static: a cartridge is inserted |
| xram_fitted | input | 4 | Static: fitted expansion banks (lower A, lower B, upper A, upper B) |
| chip_sel | output | 9 | One-hot target select (boot, cart, cart win A, cart win B, base, lower A, lower B, upper A, upper B) |
| wr_en | output | 9 | Write enable per target, same bit order |
| read_empty | output | 1 | No memory answers; read data must be 0xFF |
| mem_offset | output | 15 | Offset of the access within its 32 KB half |
| caps_led_on | output | 1 | Caps-lock indicator, 1 lights it |

## Verification
The assertions take for granted that reduced_ram, cart_fitted and xram_fitted are static straps. They also assume that the control register changes only through ctl_wr_en, so a cycle's decode depends only on the register value from the previous edge and the current address. The stimulus changes the straps only at falling edges, between register loads, and never while a check is pending. Address and write strobe are set at a falling edge and sampled a few nanoseconds later. The bench sweeps all 256 control bytes over the four 16 KB quarters, with reads and writes, under several fitted patterns and both RAM models.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

  localparam int CTL_W = 8;
  localparam int N_TGT = 9;

  // control bit positions (active low unless noted)
  localparam int B_CART  = 0;
  localparam int B_LO_A  = 1;
  localparam int B_HI_A  = 2;
  localparam int B_LO_B  = 3;
  localparam int B_HI_B  = 4;
  localparam int B_CAPS  = 5;
  localparam int B_WIN_A = 6;
  localparam int B_WIN_B = 7;

  typedef enum logic [3:0] {
    T_BOOT    = 4'd0,
    T_CART_LO = 4'd1,
    T_WIN_A   = 4'd2,
    T_WIN_B   = 4'd3,
    T_BASE    = 4'd4,
    T_XLO_A   = 4'd5,
    T_XLO_B   = 4'd6,
    T_XHI_A   = 4'd7,
    T_XHI_B   = 4'd8,
    T_NONE    = 4'd9
  } tgt_e;

  typedef enum logic [1:0] {LO_BOOT, LO_CART, LO_XA, LO_XB} lo_src_e;
  typedef enum logic [1:0] {HI_BASE, HI_XA, HI_XB, HI_WIN} hi_src_e;

  // lower-half priority chain: cart > bank A > bank B > boot ROM
  function automatic lo_src_e lo_pick(input logic cart_n, input logic xa_n,
                                      input logic xb_n);
    if (!cart_n)    return LO_CART;
    else if (!xa_n) return LO_XA;
    else if (!xb_n) return LO_XB;
    return LO_BOOT;
  endfunction

  // does the cartridge window cover this quarter of the upper half
  function automatic logic win_open(input logic cart_n, input logic wa_n,
                                    input logic wb_n, input logic q_hi);
    return !cart_n && (q_hi ? !wb_n : !wa_n);
  endfunction

  // upper-half priority chain: window > bank A > bank B > base RAM
  function automatic hi_src_e hi_pick(input logic win, input logic xa_n,
                                      input logic xb_n);
    if (win)        return HI_WIN;
    else if (!xa_n) return HI_XA;
    else if (!xb_n) return HI_XB;
    return HI_BASE;
  endfunction

  function automatic logic is_ram(input tgt_e t);
    return (t == T_BASE) || (t == T_XLO_A) || (t == T_XLO_B) ||
           (t == T_XHI_A) || (t == T_XHI_B);
  endfunction

endpackage

// File: rtl/bank_ctl_reg.sv
module bank_ctl_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (load) q <= d;
  end

endmodule

// File: rtl/bank_lo_decode.sv
module bank_lo_decode
  import bankmap_pkg::*;
(
  input  logic       cart_n,
  input  logic       xa_n,
  input  logic       xb_n,
  input  logic       cart_fitted,
  input  logic [1:0] x_fitted,
  output lo_src_e    src,
  output tgt_e       tgt
);

  always_comb begin
    src = lo_pick(cart_n, xa_n, xb_n);
    unique case (src)
      LO_CART: tgt = cart_fitted ? T_CART_LO : T_NONE;
      LO_XA:   tgt = x_fitted[0] ? T_XLO_A   : T_NONE;
      LO_XB:   tgt = x_fitted[1] ? T_XLO_B   : T_NONE;
      default: tgt = T_BOOT;
    endcase
  end

endmodule

// File: rtl/bank_hi_decode.sv
module bank_hi_decode
  import bankmap_pkg::*;
(
  input  logic       cart_n,
  input  logic       wa_n,
  input  logic       wb_n,
  input  logic       xa_n,
  input  logic       xb_n,
  input  logic       q_hi,
  input  logic       reduced,
  input  logic       cart_fitted,
  input  logic [1:0] x_fitted,
  output hi_src_e    src,
  output logic       win_hit,
  output logic       base_blank,
  output tgt_e       tgt
);

  always_comb begin
    win_hit    = win_open(cart_n, wa_n, wb_n, q_hi);
    src        = hi_pick(win_hit, xa_n, xb_n);
    base_blank = reduced && !q_hi;
    unique case (src)
      HI_WIN:  tgt = !cart_fitted ? T_NONE : (q_hi ? T_WIN_B : T_WIN_A);
      HI_XA:   tgt = x_fitted[0] ? T_XHI_A : T_NONE;
      HI_XB:   tgt = x_fitted[1] ? T_XHI_B : T_NONE;
      default: tgt = base_blank ? T_NONE : T_BASE;
    endcase
  end

endmodule

// File: rtl/bank_map_top.sv
module bank_map_top
  import bankmap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [CTL_W-1:0]  ctl_wr_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              reduced_ram,
  input  logic              cart_fitted,
  input  logic [3:0]        xram_fitted,
  output logic [N_TGT-1:0]  chip_sel,
  output logic [N_TGT-1:0]  wr_en,
  output logic              read_empty,
  output logic [ADDR_W-2:0] mem_offset,
  output logic              caps_led_on
);

  localparam int HALF_BIT = ADDR_W - 1;
  localparam int QTR_BIT  = ADDR_W - 2;

  logic [CTL_W-1:0] ctl_q;
  lo_src_e lo_src;
  hi_src_e hi_src;
  tgt_e    lo_tgt, hi_tgt, act_tgt;
  logic    upper_half, win_hit, base_blank, wr_allowed;

  bank_ctl_reg #(.W(CTL_W), .RST_VAL('1)) u_reg (
    .clk(clk), .rst_n(rst_n), .load(ctl_wr_en), .d(ctl_wr_data), .q(ctl_q)
  );

  bank_lo_decode u_lo (
    .cart_n(ctl_q[B_CART]), .xa_n(ctl_q[B_LO_A]), .xb_n(ctl_q[B_LO_B]),
    .cart_fitted(cart_fitted), .x_fitted(xram_fitted[1:0]),
    .src(lo_src), .tgt(lo_tgt)
  );

  bank_hi_decode u_hi (
    .cart_n(ctl_q[B_CART]), .wa_n(ctl_q[B_WIN_A]), .wb_n(ctl_q[B_WIN_B]),
    .xa_n(ctl_q[B_HI_A]), .xb_n(ctl_q[B_HI_B]), .q_hi(cpu_addr[QTR_BIT]),
    .reduced(reduced_ram), .cart_fitted(cart_fitted),
    .x_fitted(xram_fitted[3:2]), .src(hi_src), .win_hit(win_hit),
    .base_blank(base_blank), .tgt(hi_tgt)
  );

  assign upper_half  = cpu_addr[HALF_BIT];
  assign act_tgt     = upper_half ? hi_tgt : lo_tgt;
  assign wr_allowed  = cpu_wr && is_ram(act_tgt);
  assign read_empty  = (act_tgt == T_NONE);
  assign mem_offset  = cpu_addr[ADDR_W-2:0];
  assign caps_led_on = !ctl_q[B_CAPS];

  for (genvar i = 0; i < N_TGT; i++) begin : g_sel
    assign chip_sel[i] = (act_tgt == tgt_e'(i));
    assign wr_en[i]    = chip_sel[i] && wr_allowed;
  end

endmodule

// File: rtl/bank_map_chk.sv
module bank_map_chk
  import bankmap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr_en,
  input logic [CTL_W-1:0]  ctl_wr_data,
  input logic [CTL_W-1:0]  ctl_q,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic              reduced_ram,
  input logic [N_TGT-1:0]  chip_sel,
  input logic [N_TGT-1:0]  wr_en,
  input logic              read_empty,
  input logic              caps_led_on
);

  // R10
  sel_or_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_empty ? (chip_sel == '0) : ($countones(chip_sel) == 1));

  // R5
  rom_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[3:0] == 4'd0) && ((wr_en & ~chip_sel) == '0));

  // R5
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |-> (wr_en == '0));

  // R2
  lower_targets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[ADDR_W-1] |-> (chip_sel[8:7] == 2'd0 && chip_sel[4:2] == 3'd0));

  // R3
  upper_targets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[ADDR_W-1] |-> (chip_sel[1:0] == 2'd0 && chip_sel[6:5] == 2'd0));

  // R4
  window_needs_cart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[B_CART] |-> (chip_sel[3:2] == 2'd0));

  // R6
  reduced_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reduced_ram && cpu_addr[ADDR_W-1] && !cpu_addr[ADDR_W-2])
      |-> (!chip_sel[T_BASE] && !wr_en[T_BASE]));

  // R9
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> (ctl_q == $past(ctl_wr_data)));

  // R9
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_en |=> $stable(ctl_q));

  // R8
  caps_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> (caps_led_on == !$past(ctl_wr_data[B_CAPS])));

endmodule

bind bank_map_top bank_map_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
  .ctl_q(ctl_q), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .reduced_ram(reduced_ram), .chip_sel(chip_sel), .wr_en(wr_en),
  .read_empty(read_empty), .caps_led_on(caps_led_on)
);

// File: tb/bank_map_top_test.sv
`timescale 1ns/1ps
module bank_map_top_test;

  localparam int CYC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [7:0]  ctl_wr_data = 8'h00;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_wr = 1'b0;
  logic        reduced_ram = 1'b0;
  logic        cart_fitted = 1'b1;
  logic [3:0]  xram_fitted = 4'hF;
  logic [8:0]  chip_sel, wr_en;
  logic        read_empty, caps_led_on;
  logic [14:0] mem_offset;

  bank_map_top uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .reduced_ram(reduced_ram),
    .cart_fitted(cart_fitted), .xram_fitted(xram_fitted), .chip_sel(chip_sel),
    .wr_en(wr_en), .read_empty(read_empty), .mem_offset(mem_offset),
    .caps_led_on(caps_led_on)
  );

  always #(CYC/2) clk = ~clk;

  typedef struct {
    logic [8:0]  sel;
    logic [8:0]  we;
    logic        empty;
    logic        led;
    logic [14:0] off;
    string       tag;
    string       etag;
  } exp_t;

  exp_t exp_q[$];
  event go;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] shadow = 8'hFF;

  // expected outputs from the requirements (index -1 means nothing answers)
  function automatic exp_t model(input logic [7:0] r, input logic [15:0] a,
                                 input logic wr, input logic red,
                                 input logic cf, input logic [3:0] xf);
    exp_t e;
    int idx;
    bit writable;
    bit absent = 0;
    case (a[15:14])
      2'b00, 2'b01: begin
        e.tag = "R2";
        if (!r[0])      begin idx = cf ? 1 : -1;    absent = !cf;    end
        else if (!r[1]) begin idx = xf[0] ? 5 : -1; absent = !xf[0]; end
        else if (!r[3]) begin idx = xf[1] ? 6 : -1; absent = !xf[1]; end
        else idx = 0;
      end
      default: begin
        e.tag = "R3";
        if (!r[0] && ((a[14] && !r[7]) || (!a[14] && !r[6]))) begin
          e.tag = "R4"; idx = !cf ? -1 : (a[14] ? 3 : 2); absent = !cf;
        end
        else if (!r[2]) begin idx = xf[2] ? 7 : -1; absent = !xf[2]; end
        else if (!r[4]) begin idx = xf[3] ? 8 : -1; absent = !xf[3]; end
        else if (red && !a[14]) begin idx = -1; e.tag = "R6"; end
        else idx = 4;
      end
    endcase
    writable = (idx == 4) || (idx >= 5);
    e.sel   = (idx >= 0) ? (9'd1 << idx) : 9'd0;
    e.we    = (writable && wr) ? e.sel : 9'd0;
    e.empty = (idx < 0);
    e.led   = ~r[5];
    e.off   = a[14:0];
    e.etag  = absent ? "R7" : "R10";
    return e;
  endfunction

  task automatic fail_line(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // driver: apply one access and queue its expectation
  task automatic access(input logic [15:0] a, input logic wr, input string force_tag);
    exp_t e;
    @(negedge clk);
    cpu_addr = a;
    cpu_wr   = wr;
    e = model(shadow, a, wr, reduced_ram, cart_fitted, xram_fitted);
    if (force_tag != "") begin e.tag = force_tag; e.etag = force_tag; end
    exp_q.push_back(e);
    -> go;
  endtask

  task automatic load_ctl(input logic [7:0] v);
    @(negedge clk);
    ctl_wr_en   = 1'b1;
    ctl_wr_data = v;
    @(negedge clk);
    ctl_wr_en   = 1'b0;
    shadow      = v;
  endtask

  // monitor: compare design outputs with the queued expectation
  initial begin
    forever begin
      exp_t e;
      @(go);
      #2;
      e = exp_q.pop_front();
      checks++;
      if (chip_sel !== e.sel) fail_line(e.tag, "chip_sel", 32'(chip_sel), 32'(e.sel));
      checks++;
      if (wr_en !== e.we) fail_line((e.tag == "R1") ? e.tag : "R5", "wr_en", 32'(wr_en), 32'(e.we));
      checks++;
      if (read_empty !== e.empty) fail_line(e.etag, "read_empty", 32'(read_empty), 32'(e.empty));
      checks++;
      if (caps_led_on !== e.led) fail_line((e.tag == "R1") ? e.tag : "R8", "caps_led_on", 32'(caps_led_on), 32'(e.led));
      checks++;
      if (mem_offset !== e.off) fail_line(e.tag, "mem_offset", 32'(mem_offset), 32'(e.off));
    end
  end

  initial begin
    #(CYC * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] xf_set [4] = '{4'hF, 4'h0, 4'h5, 4'hA};
    logic       cf_set [4] = '{1'b1, 1'b0, 1'b1, 1'b0};
    logic [15:0] quarter [4] = '{16'h0123, 16'h4567, 16'h89AB, 16'hCDEF};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset value selects boot ROM low, base RAM high, LED dark
    access(16'h0000, 1'b0, "R1");
    access(16'h9000, 1'b1, "R1");
    access(16'hF000, 1'b0, "R1");

    // R9: load takes effect, then data bus changes without the strobe
    load_ctl(8'h00);
    access(16'h1000, 1'b1, "R9");
    @(negedge clk);
    ctl_wr_data = 8'hFF;
    @(negedge clk);
    ctl_wr_data = 8'h5A;
    access(16'h1000, 1'b0, "R9");
    access(16'hC000, 1'b1, "R9");

    for (int p = 0; p < 4; p++) begin
      for (int red = 0; red < 2; red++) begin
        @(negedge clk);
        cart_fitted = cf_set[p];
        xram_fitted = xf_set[p];
        reduced_ram = red[0];
        for (int r = 0; r < 256; r++) begin
          load_ctl(8'(r));
          for (int q = 0; q < 4; q++) access(quarter[q], 1'b1, "");
          access(quarter[0], 1'b0, "");
          access(quarter[2], 1'b0, "");
        end
      end
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule